// File: doc/BRIEF.md
# Register-Operand Add-With-Carry Execute Unit

This unit takes one 32-bit instruction word of the wide register form of add-with-carry, decodes it against a fixed bit layout and executes it. It presents the indices of the two source registers and the destination register. The surrounding logic supplies the two source values and the current condition flags. The unit shifts the second source by an immediate amount, adds the first source, the shifted value and the carry flag, and produces the sum and the next flag values. Sum, flags, indices and the illegal indication are combinational from the word and the operands. The register-file write enable is registered and rises in the cycle after an accepted valid strobe.

A two-state controller sequences the write. The states are `ST_IDLE` and `ST_WRITE`. The ACCEPT transition goes from either state to `ST_WRITE` when the valid strobe is high and the word is legal. The RETIRE transition goes from either state to `ST_IDLE` when the valid strobe is low or the word is illegal. The write enable is high exactly while the controller is in `ST_WRITE`. The source, so the instruction word and operands, must stay stable during the valid cycle and the cycle that follows it.

Top module: `carry_add_unit`

## Requirements
- R1: The word is recognised only when bits 31:25 are 1110101, bits 24:21 are 1010 and bit 15 is 0. Any other word raises `illegal`.
- R2: The source index `rn_idx` is bits 19:16, the destination index `rd_idx` is bits 11:8 and the second source index `rm_idx` is bits 3:0.
- R3: If any of the three register indices is 13 or 15, `illegal` is raised. An illegal word never produces a write, and its flags stay unchanged.
- R4: `wr_data` equals `rn_data` plus the shifted `rm_data` plus the current carry, modulo 2^32.
- R5: The shift amount is {bits 14:12, bits 7:6}, with bits 14:12 as the upper part. Shift type bits 5:4 select the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. An amount of 0 means no shift for type 00, and a shift by 32 for types 01 and 10.
- R6: Type 11 with an amount of 0 is a one-bit rotate right through carry: the old carry enters bit 31 and bit 0 is dropped.
- R7: Flags are packed as `{N,Z,C,V}` in bits 3:0. When bit 20 (the set-flags bit) is 1, N takes bit 31 of the sum and Z is 1 exactly when the sum is zero.
- R8: When bit 20 is 1, C takes the unsigned carry out of the three-input 32-bit add. V is 1 when that add overflows as a signed operation. The shifter's own carry-out never reaches C.
- R9: When bit 20 is 0, `flags_out` equals `flags_in`.
- R10: `wr_en` is 0 after reset. It is 1 in the cycle after a cycle with `instr_valid` high and a legal word, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| rn_data | input | 32 | Value of the register selected by `rn_idx` |
| rm_data | input | 32 | Value of the register selected by `rm_idx` |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| rn_idx | output | 4 | First source register index |
| rm_idx | output | 4 | Second source register index |
| rd_idx | output | 4 | Destination register index |
| wr_en | output | 1 | Register write enable, one cycle after acceptance |
| wr_data | output | 32 | Sum to be written |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| illegal | output | 1 | Word does not match the layout or uses a reserved index |

## Verification
The assertions watch the following on every cycle:
- the write-enable timing against the valid strobe and the illegal indication;
- flag preservation when bit 20 is clear;
- the consistency of N and Z with the written sum.

The arithmetic itself can only be shown by the scoreboard scenarios, which compare against an independent reference model:
- each shift type at amounts 0, 1 and 31;
- the rotate through carry with both carry values;
- unsigned carry-out and signed overflow;
- reserved indices and opcode mismatches.

// File: rtl/carry_add_pkg.sv
package carry_add_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;
    localparam int AMT_W  = $clog2(WORD_W);
    localparam logic [6:0] OP_HI  = 7'b1110101;
    localparam logic [3:0] OP_MID = 4'b1010;

    typedef enum logic [1:0] {SH_LSL = 2'b00, SH_LSR = 2'b01,
                              SH_ASR = 2'b10, SH_ROR = 2'b11} shift_kind_t;
    typedef struct packed { logic n; logic z; logic c; logic v; } nzcv_t;
    typedef enum logic {ST_IDLE, ST_WRITE} wr_state_t;
endpackage

// File: rtl/carry_add_decode.sv
module carry_add_decode
    import carry_add_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              set_flags,
    output logic [IDX_W-1:0]  rn,
    output logic [IDX_W-1:0]  rd,
    output logic [IDX_W-1:0]  rm,
    output shift_kind_t       kind,
    output logic [AMT_W-1:0]  amount,
    output logic              bad
);
    function automatic logic reserved_idx(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(13)) || (idx == IDX_W'(15));
    endfunction

    logic opcode_ok;

    always_comb begin
        set_flags = word[20];
        rn        = word[19:16];
        rd        = word[11:8];
        rm        = word[3:0];
        kind      = shift_kind_t'(word[5:4]);
        amount    = {word[14:12], word[7:6]};
        opcode_ok = (word[31:25] == OP_HI) && (word[24:21] == OP_MID) && !word[15];
        bad       = !opcode_ok || reserved_idx(rn) || reserved_idx(rd) || reserved_idx(rm);
    end
endmodule

// File: rtl/carry_add_shift.sv
module carry_add_shift
    import carry_add_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  shift_kind_t   kind,
    input  logic [AW-1:0] amount,
    input  logic          carry_in,
    output logic [W-1:0]  shifted
);
    localparam logic [AW:0] FULL = (AW+1)'(W);

    logic          zero_amt;
    logic [AW:0]   back_amt;

    always_comb begin
        zero_amt = (amount == '0);
        back_amt = FULL - {1'b0, amount};
        unique case (kind)
            SH_LSL: shifted = value << amount;
            SH_LSR: shifted = zero_amt ? '0 : (value >> amount);
            SH_ASR: shifted = zero_amt ? {W{value[W-1]}}
                                       : W'($signed(value) >>> amount);
            SH_ROR: shifted = zero_amt ? {carry_in, value[W-1:1]}
                                       : ((value >> amount) | (value << back_amt));
            default: shifted = value;
        endcase
    end
endmodule

// File: rtl/carry_add_core.sv
module carry_add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/carry_add_unit.sv
module carry_add_unit
    import carry_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [WORD_W-1:0] rn_data,
    input  logic [WORD_W-1:0] rm_data,
    input  logic [3:0]        flags_in,
    output logic [IDX_W-1:0]  rn_idx,
    output logic [IDX_W-1:0]  rm_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [3:0]        flags_out,
    output logic              illegal
);
    wr_state_t         state, state_nx;
    logic              set_flags;
    shift_kind_t       kind;
    logic [AMT_W-1:0]  amount;
    logic [WORD_W-1:0] operand_b;
    logic              add_c, add_v;
    nzcv_t             cur, nxt;

    assign cur = nzcv_t'(flags_in);

    carry_add_decode u_dec (
        .word(instr_word), .set_flags(set_flags), .rn(rn_idx), .rd(rd_idx),
        .rm(rm_idx), .kind(kind), .amount(amount), .bad(illegal)
    );

    carry_add_shift #(.W(WORD_W)) u_shf (
        .value(rm_data), .kind(kind), .amount(amount), .carry_in(cur.c),
        .shifted(operand_b)
    );

    carry_add_core #(.W(WORD_W)) u_add (
        .a(rn_data), .b(operand_b), .cin(cur.c), .sum(wr_data),
        .cout(add_c), .ovf(add_v)
    );

    always_comb begin
        nxt = cur;
        if (set_flags && !illegal) begin
            nxt.n = wr_data[WORD_W-1];
            nxt.z = (wr_data == '0);
            nxt.c = add_c;
            nxt.v = add_v;
        end
        flags_out = nxt;
    end

    // ACCEPT / RETIRE transitions
    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = (instr_valid && !illegal) ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_nx = (instr_valid && !illegal) ? ST_WRITE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_WRITE: wr_en = 1'b1;
            default:  wr_en = 1'b0;
        endcase
    end

    // R9
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_word[20]) |-> (flags_out == flags_in));
    // R3
    no_write_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && illegal) |=> !wr_en);
    // R10
    write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !illegal) |=> wr_en);
    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !wr_en);
    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && set_flags && !illegal) |-> (flags_out[3] == wr_data[WORD_W-1]));
    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && set_flags && !illegal) |-> (flags_out[2] == (wr_data == '0)));
endmodule

// File: tb/test_carry_add_unit.sv
module test_carry_add_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = 32'h0;
    logic [31:0] rn_data, rm_data;
    logic [3:0]  flags_in;
    logic [3:0]  rn_idx, rm_idx, rd_idx;
    logic        wr_en, illegal;
    logic [31:0] wr_data;
    logic [3:0]  flags_out;

    logic [31:0] regs [16];
    logic [3:0]  flags = 4'b0000;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic        ill;
        logic [3:0]  rd;
        logic [31:0] data;
        logic [3:0]  fl;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    assign rn_data  = regs[rn_idx];
    assign rm_data  = regs[rm_idx];
    assign flags_in = flags;

    carry_add_unit i_carry_add_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .rn_data(rn_data), .rm_data(rm_data), .flags_in(flags_in),
        .rn_idx(rn_idx), .rm_idx(rm_idx), .rd_idx(rd_idx), .wr_en(wr_en),
        .wr_data(wr_data), .flags_out(flags_out), .illegal(illegal)
    );

    function automatic logic [31:0] enc(input logic s, input logic [3:0] rn, input logic [3:0] rd,
                                        input logic [3:0] rm, input logic [1:0] typ,
                                        input logic [4:0] amt);
        return {7'b1110101, 4'b1010, s, rn, 1'b0, amt[4:2], rd, amt[1:0], typ, rm};
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] x, input logic [1:0] typ,
                                              input int amt, input logic c);
        logic [63:0] ext;
        case (typ)
            2'b00: return x << amt;
            2'b01: begin ext = {32'h0, x}; return (amt == 0) ? 32'h0 : ext[31+amt -: 32] >> 0 & 32'h0 | (x >> amt); end
            2'b10: begin
                ext = {{32{x[31]}}, x};
                return (amt == 0) ? ext[63:32] : ext[amt +: 32];
            end
            default: begin
                ext = {x, x};
                return (amt == 0) ? {c, x[31:1]} : ext[amt +: 32];
            end
        endcase
    endfunction

    function automatic logic ref_bad(input logic [31:0] w);
        logic [3:0] a, b, d;
        a = w[19:16]; d = w[11:8]; b = w[3:0];
        if (w[31:21] != 11'b11101011010 || w[15]) return 1'b1;
        return (a == 13 || a == 15 || b == 13 || b == 15 || d == 13 || d == 15);
    endfunction

    task automatic issue(input logic [31:0] w, input string tag);
        item_t it;
        longint sgn;
        logic [32:0] u;
        logic [31:0] sh, ra;
        logic c;
        @(negedge clk);
        instr_word  = w;
        instr_valid = 1'b1;
        c  = flags[1];
        ra = regs[w[19:16]];
        sh = ref_shift(regs[w[3:0]], w[5:4], int'({w[14:12], w[7:6]}), c);
        u  = 33'(ra) + 33'(sh) + 33'(c);
        sgn = longint'($signed(ra)) + longint'($signed(sh)) + longint'(c);
        it.tag  = tag;
        it.ill  = ref_bad(w);
        it.rd   = w[11:8];
        it.data = u[31:0];
        it.fl   = flags;
        if (!it.ill && w[20])
            it.fl = {u[31], u[31:0] == 32'h0, u[32], (sgn > 64'sd2147483647) || (sgn < -64'sd2147483648)};
        sb_q.push_back(it);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // Monitor: compares one cycle after each driven word, and checks idle cycles
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !finished) begin
                if (sb_q.size() != 0) begin
                    it = sb_q.pop_front();
                    checks++;
                    if (illegal !== it.ill || wr_en !== !it.ill || flags_out !== it.fl ||
                        (!it.ill && (wr_data !== it.data || rd_idx !== it.rd))) begin
                        errors++;
                        $display("FAIL %s: ill=%b we=%b rd=%0d data=%h fl=%b expected ill=%b we=%b rd=%0d data=%h fl=%b",
                                 it.tag, illegal, wr_en, rd_idx, wr_data, flags_out,
                                 it.ill, !it.ill, it.rd, it.data, it.fl);
                    end
                    if (!it.ill) begin
                        regs[it.rd] = it.data;
                    end
                    flags = it.fl;
                end else if (!instr_valid) begin
                    checks++;
                    if (wr_en !== 1'b0) begin
                        errors++;
                        $display("FAIL R10 idle: wr_en=%b expected 0", wr_en);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 * i + 32'h0123_4567;
        repeat (3) @(negedge clk);
        checks++;
        if (wr_en !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: wr_en=%b expected 0", wr_en);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        regs[1] = 32'h0000_0010; regs[2] = 32'h8000_0003;
        for (int t = 0; t < 4; t++) begin
            issue(enc(1'b1, 4'd1, 4'd3, 4'd2, 2'(t), 5'd1),  "R5 amt1");
            issue(enc(1'b1, 4'd1, 4'd4, 4'd2, 2'(t), 5'd31), "R5 amt31");
            issue(enc(1'b1, 4'd1, 4'd5, 4'd2, 2'(t), 5'd0),  "R5 amt0");
        end
        // rotate through carry with C=1 then C=0
        flags = 4'b0010;
        issue(enc(1'b0, 4'd1, 4'd6, 4'd2, 2'b11, 5'd0), "R6 carry1");
        flags = 4'b0000;
        issue(enc(1'b0, 4'd1, 4'd6, 4'd2, 2'b11, 5'd0), "R6 carry0");
        // carry out and zero
        regs[7] = 32'hFFFF_FFFF; regs[8] = 32'h0000_0001; flags = 4'b0000;
        issue(enc(1'b1, 4'd7, 4'd9, 4'd8, 2'b00, 5'd0), "R8 carry R7 zero");
        // signed overflow via carry-in
        regs[7] = 32'h7FFF_FFFF; regs[8] = 32'h0; flags = 4'b0010;
        issue(enc(1'b1, 4'd7, 4'd9, 4'd8, 2'b00, 5'd0), "R8 overflow R4");
        // S clear keeps flags
        flags = 4'b1011;
        issue(enc(1'b0, 4'd7, 4'd10, 4'd8, 2'b00, 5'd0), "R9 hold");
        // reserved indices
        issue(enc(1'b1, 4'd1, 4'd13, 4'd2, 2'b00, 5'd0), "R3 rd13");
        issue(enc(1'b1, 4'd15, 4'd3, 4'd2, 2'b00, 5'd0), "R3 rn15");
        issue(enc(1'b1, 4'd1, 4'd3, 4'd13, 2'b00, 5'd0), "R3 rm13");
        // opcode mismatches
        issue(enc(1'b1, 4'd1, 4'd3, 4'd2, 2'b00, 5'd0) | 32'h0000_8000, "R1 bit15");
        issue(enc(1'b1, 4'd1, 4'd3, 4'd2, 2'b00, 5'd0) ^ 32'h0020_0000, "R1 mid");
        issue(enc(1'b1, 4'd1, 4'd3, 4'd2, 2'b00, 5'd0) ^ 32'h0200_0000, "R1 hi");
        // random legal traffic, destination checked through rd_idx
        for (int k = 0; k < 300; k++) begin
            int a, b, d;
            a = $urandom_range(0, 13); if (a == 13) a = 14;
            b = $urandom_range(0, 13); if (b == 13) b = 14;
            d = $urandom_range(0, 13); if (d == 13) d = 14;
            regs[a] = $urandom; regs[b] = $urandom;
            issue(enc(1'($urandom), 4'(a), 4'(d), 4'(b), 2'($urandom), 5'($urandom)), "R2 R4 random");
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule